// File: doc/BRIEF.md
# Checksummed Serial Configuration Register Loader

This block receives configuration frames over a three-wire serial port made of a data line, a bit clock and a frame strobe. It oversamples all three lines with the system clock. A frame is 72 bits long and is sent lowest-numbered bit first (D00 through D71).

When the strobe rises, the block checks the collected frame in three ways: the bit count, an 8-bit chip identifier, and a modulo-256 byte checksum. The checksum test can be turned off with a pin. A frame that passes all three is parked in one of two pending banks, chosen by a category bit: the control bank or the adjustment bank.

Pending data moves into the active registers only at a sync-aligned instant. That instant is the falling edge of the horizontal sync during the readout line, provided no multi-field exposure is running and no bank has already been committed in the current vertical interval. Two control fields bypass this wait and take effect as soon as the strobe rises: the 2-bit power-state field and the sync-generator enable bit.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst_n` is low, every output is zero. This covers both register banks, the power state, the sync enable, the commit pulse and both reject flags.
- R2: A frame is accepted only if byte D00–D07 equals 0x81, which means D00 and D07 are one and D01–D06 are zero. On a full-length frame with any other identifier, `reject_id` is set and nothing else changes.
- R3: When `sum_bypass` is low, a frame is accepted only if the modulo-256 sum of its nine bytes is zero. The nine bytes are D00–D07, D08–D15, and so on up to D64–D71, with D(8k) as the LSB of byte k. Otherwise `reject_sum` is set.
- R4: When `sum_bypass` is high, the checksum has no effect on acceptance.
- R5: A frame is discarded without any visible effect if the strobe rises after any bit count other than 72. The count restarts when the strobe falls, so the next full frame is processed normally.
- R6: D08 selects the destination bank: 0 selects the control bank and 1 selects the adjustment bank. Bit i of the 48-bit payload is frame bit D(16+i).
- R7: Pending data is committed on a falling edge of `hsync` only while `readout_line` is high. The register update and a one-cycle `commit_pulse` both appear on the clock edge that follows the first low sample of `hsync`.
- R8: At most one bank is committed per vertical interval, and a new interval starts on each rising edge of `vsync`. If both banks are pending, the control bank goes first and the adjustment bank waits for a later interval.
- R9: A later accepted frame of the same category overwrites data that is still pending.
- R10: On an accepted control frame, `pwr_state` takes D63:D62 and `sync_en` takes D52 as soon as the strobe rises, without waiting for a commit.
- R11: No commit happens while `exposure_busy` is high.
- R12: The reject flags are sticky and are cleared by the next accepted frame. If a frame fails both the identifier and the checksum test, only `reject_id` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata | input | 1 | Serial data, sampled on the rise of `sclk` |
| sclk | input | 1 | Serial bit clock |
| sstrobe | input | 1 | Frame strobe; low during a transfer, and its rise closes the frame |
| sum_bypass | input | 1 | High disables the checksum test |
| hsync | input | 1 | Horizontal sync; its falling edge is the commit instant |
| vsync | input | 1 | Vertical sync; its rising edge starts a new interval |
| readout_line | input | 1 | High during the line that allows commits |
| exposure_busy | input | 1 | High while a multi-field exposure blocks commits |
| ctrl_reg | output | 48 | Active control bank (frame bits D16–D63) |
| adj_reg | output | 48 | Active adjustment bank (frame bits D16–D63) |
| pwr_state | output | 2 | Immediate power-state field (D63:D62) |
| sync_en | output | 1 | Immediate sync-generator enable (D52) |
| commit_pulse | output | 1 | One-cycle pulse on each commit |
| reject_id | output | 1 | Sticky: last rejection was an identifier mismatch |
| reject_sum | output | 1 | Sticky: a frame failed the checksum |

## Verification
The hardest state to reach is having both banks pending at once, so that the one-bank-per-interval rule must hold one bank back. The stimulus reaches it by loading a control frame and an adjustment frame, with an extra control frame that overwrites the first, before any sync fall. A second sync fall in the same interval must then do nothing, and only the fall after a `vsync` may release the adjustment bank. Commits are also attempted with `readout_line` low and with `exposure_busy` high, to check that both gates hold the pending data back.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int          FRAME_BITS  = 72,
  parameter logic [7:0]  CHIP_ID     = 8'h81,
  parameter int          PWR_LSB     = 62,
  parameter int          SYNC_EN_BIT = 52,
  localparam int         PAY_W       = FRAME_BITS - 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdata,
  input  logic             sclk,
  input  logic             sstrobe,
  input  logic             sum_bypass,
  input  logic             hsync,
  input  logic             vsync,
  input  logic             readout_line,
  input  logic             exposure_busy,
  output logic [PAY_W-1:0] ctrl_reg,
  output logic [PAY_W-1:0] adj_reg,
  output logic [1:0]       pwr_state,
  output logic             sync_en,
  output logic             commit_pulse,
  output logic             reject_id,
  output logic             reject_sum
);
  localparam int NBYTES  = FRAME_BITS / 8;
  localparam int CW      = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_BITS);
  localparam logic [CW-1:0] CNT_MAX  = CW'(FRAME_BITS + 1);

  logic [2:0] sck_s, sen_s, sd_s;
  logic [FRAME_BITS-1:0] frame;
  logic [CW-1:0] cnt;
  logic [7:0] sum;
  logic hs_q, vs_q, v_used;
  logic pc_v, pa_v;
  logic [PAY_W-1:0] pc_d, pa_d;

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire sen_rise = sen_s[1] & ~sen_s[2];
  wire sen_fall = ~sen_s[1] & sen_s[2];
  wire sen_low  = ~sen_s[1];

  always_comb begin
    sum = '0;
    for (int i = 0; i < NBYTES; i++) sum = sum + frame[i*8 +: 8];
  end

  wire frame_done = sen_rise && (cnt == CNT_FULL);
  wire id_ok      = frame[7:0] == CHIP_ID;
  wire sum_ok     = sum_bypass || (sum == 8'd0);
  wire accept     = frame_done && id_ok && sum_ok;
  wire cat_adj    = frame[8];
  wire [PAY_W-1:0] payload = frame[16 +: PAY_W];

  wire hs_fall = hs_q & ~hsync;
  wire vs_rise = vsync & ~vs_q;
  wire commit  = hs_fall && readout_line && !exposure_busy && !v_used && (pc_v || pa_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0;
      sen_s <= 3'b111;
      sd_s  <= '0;
      frame <= '0;
      cnt   <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sclk};
      sen_s <= {sen_s[1:0], sstrobe};
      sd_s  <= {sd_s[1:0], sdata};
      if (sen_fall) begin
        cnt <= '0;
      end else if (sck_rise && sen_low) begin
        frame <= {sd_s[1], frame[FRAME_BITS-1:1]};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q         <= 1'b0;
      vs_q         <= 1'b0;
      v_used       <= 1'b0;
      pc_v         <= 1'b0;
      pa_v         <= 1'b0;
      pc_d         <= '0;
      pa_d         <= '0;
      ctrl_reg     <= '0;
      adj_reg      <= '0;
      pwr_state    <= '0;
      sync_en      <= 1'b0;
      commit_pulse <= 1'b0;
      reject_id    <= 1'b0;
      reject_sum   <= 1'b0;
    end else begin
      hs_q         <= hsync;
      vs_q         <= vsync;
      commit_pulse <= commit;

      if (commit)       v_used <= 1'b1;
      else if (vs_rise) v_used <= 1'b0;

      if (commit) begin
        if (pc_v) begin
          ctrl_reg <= pc_d;
          pc_v     <= 1'b0;
        end else begin
          adj_reg <= pa_d;
          pa_v    <= 1'b0;
        end
      end

      if (accept) begin
        reject_id  <= 1'b0;
        reject_sum <= 1'b0;
        if (cat_adj) begin
          pa_d <= payload;
          pa_v <= 1'b1;
        end else begin
          pc_d      <= payload;
          pc_v      <= 1'b1;
          pwr_state <= frame[PWR_LSB +: 2];
          sync_en   <= frame[SYNC_EN_BIT];
        end
      end else if (frame_done && !id_ok) begin
        reject_id <= 1'b1;
      end else if (frame_done && !sum_ok) begin
        reject_sum <= 1'b1;
      end
    end
  end
endmodule

module serial_cfg_loader_chk #(
  parameter int PAY_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             readout_line,
  input logic             exposure_busy,
  input logic [PAY_W-1:0] ctrl_reg,
  input logic [PAY_W-1:0] adj_reg,
  input logic [1:0]       pwr_state,
  input logic             sync_en,
  input logic             commit_pulse,
  input logic             reject_id,
  input logic             reject_sum
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_reg == '0 && adj_reg == '0 && pwr_state == 2'b00 &&
                      !sync_en && !commit_pulse && !reject_id && !reject_sum));

  assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> !commit_pulse);

  assert_commit_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> $past(readout_line && !exposure_busy));

  assert_ctrl_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_reg) |-> commit_pulse);

  assert_adj_on_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adj_reg) |-> commit_pulse);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(.PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .readout_line(readout_line), .exposure_busy(exposure_busy),
  .ctrl_reg(ctrl_reg), .adj_reg(adj_reg), .pwr_state(pwr_state), .sync_en(sync_en),
  .commit_pulse(commit_pulse), .reject_id(reject_id), .reject_sum(reject_sum)
);

// File: tb/serial_cfg_loader_tb.sv
module serial_cfg_loader_tb;
  localparam int FB = 72;
  localparam int PW = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, sstrobe = 1'b1, sum_bypass = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0, readout_line = 1'b0, exposure_busy = 1'b0;
  logic [PW-1:0] ctrl_reg, adj_reg;
  logic [1:0] pwr_state;
  logic sync_en, commit_pulse, reject_id, reject_sum;

  int checks = 0;
  int fails = 0;
  int ncommit = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .sclk(sclk), .sstrobe(sstrobe),
    .sum_bypass(sum_bypass), .hsync(hsync), .vsync(vsync), .readout_line(readout_line),
    .exposure_busy(exposure_busy), .ctrl_reg(ctrl_reg), .adj_reg(adj_reg),
    .pwr_state(pwr_state), .sync_en(sync_en), .commit_pulse(commit_pulse),
    .reject_id(reject_id), .reject_sum(reject_sum)
  );

  always @(negedge clk) if (rst_n && commit_pulse) ncommit++;

  // entry: {id[7:0], cat, bypass, corrupt, payload[47:0], exp_reject_id, exp_reject_sum}
  localparam int NV = 6;
  localparam logic [60:0] TBL [NV] = '{
    {8'h81, 1'b0, 1'b0, 1'b0, 48'hC010_0000_1234, 1'b0, 1'b0},
    {8'h80, 1'b0, 1'b0, 1'b0, 48'h8000_0000_0001, 1'b1, 1'b0},
    {8'h81, 1'b1, 1'b0, 1'b1, 48'h0000_5555_0000, 1'b1, 1'b1},
    {8'h81, 1'b1, 1'b1, 1'b1, 48'h0123_4567_89AB, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b0, 1'b1, 48'hFFFF_0000_0000, 1'b1, 1'b0},
    {8'h81, 1'b0, 1'b0, 1'b0, 48'h4000_0000_0F0F, 1'b0, 1'b0}
  };

  function automatic logic [FB-1:0] mk(input logic [7:0] id, input logic cat,
                                       input logic [PW-1:0] pay, input logic corrupt);
    logic [FB-1:0] f;
    logic [7:0] s;
    f = '0;
    f[7:0] = id;
    f[8] = cat;
    f[16 +: PW] = pay;
    s = 8'd0;
    for (int k = 0; k < 8; k++) s = s + f[k*8 +: 8];
    f[71:64] = 8'd0 - s + {7'd0, corrupt};
    return f;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [FB-1:0] f, input int n);
    @(negedge clk) sstrobe = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdata = (i < FB) ? f[i] : 1'b0;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    sstrobe = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic hs_pulse(output logic pulse_seen);
    @(negedge clk) hsync = 1'b1;
    repeat (3) @(negedge clk);
    hsync = 1'b0;
    @(negedge clk) pulse_seen = commit_pulse;
    repeat (2) @(negedge clk);
  endtask

  task automatic vs_pulse();
    @(negedge clk) vsync = 1'b1;
    repeat (2) @(negedge clk);
    vsync = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] exp_pwr;
    logic exp_sync, p;
    int c0;
    logic [PW-1:0] p2;
    exp_pwr = 2'b00;
    exp_sync = 1'b0;

    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", 64'(ctrl_reg), 64'd0);
    chk("R1 reset flags", {59'd0, pwr_state, sync_en, reject_id, reject_sum}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [60:0] e;
      logic acc;
      e = TBL[v];
      sum_bypass = e[51];
      send(mk(e[60:53], e[52], e[49:2], e[50]), FB);
      acc = (e[60:53] == 8'h81) && (e[51] || !e[50]);
      if (acc && !e[52]) begin
        exp_pwr = e[49:48];
        exp_sync = e[38];
      end
      chk("R2 R3 R4 R12 reject_id", 64'(reject_id), 64'(e[1]));
      chk("R3 R4 R12 reject_sum", 64'(reject_sum), 64'(e[0]));
      chk("R10 pwr_state", 64'(pwr_state), 64'(exp_pwr));
      chk("R10 sync_en", 64'(sync_en), 64'(exp_sync));
    end
    sum_bypass = 1'b0;
    chk("R7 no commit before sync ctrl", 64'(ctrl_reg), 64'd0);
    chk("R7 no commit before sync adj", 64'(adj_reg), 64'd0);

    readout_line = 1'b1;
    hs_pulse(p);
    chk("R7 commit pulse", 64'(p), 64'd1);
    chk("R9 overwritten ctrl committed", 64'(ctrl_reg), 64'h4000_0000_0F0F);
    chk("R8 adj held", 64'(adj_reg), 64'd0);
    c0 = ncommit;
    hs_pulse(p);
    chk("R8 second commit same interval", 64'(ncommit - c0), 64'd0);
    chk("R8 adj still held", 64'(adj_reg), 64'd0);

    vs_pulse();
    readout_line = 1'b0;
    hs_pulse(p);
    chk("R7 readout low no commit", 64'(adj_reg), 64'd0);
    readout_line = 1'b1;
    hs_pulse(p);
    chk("R6 adj bank committed", 64'(adj_reg), 64'h0123_4567_89AB);

    p2 = 48'h0000_0000_ABCD;
    send(mk(8'h81, 1'b0, p2, 1'b0), FB);
    vs_pulse();
    exposure_busy = 1'b1;
    c0 = ncommit;
    hs_pulse(p);
    chk("R11 busy blocks commit", 64'(ctrl_reg), 64'h4000_0000_0F0F);
    chk("R11 no pulse while busy", 64'(ncommit - c0), 64'd0);
    exposure_busy = 1'b0;
    hs_pulse(p);
    chk("R11 commit after busy", 64'(ctrl_reg), 64'(p2));

    send(mk(8'h81, 1'b0, 48'h8000_0000_0000, 1'b0), FB - 1);
    chk("R5 short frame pwr", 64'(pwr_state), 64'd0);
    chk("R5 short frame flags", {62'd0, reject_id, reject_sum}, 64'd0);
    send(mk(8'h81, 1'b0, 48'h8000_0000_0000, 1'b0), FB + 1);
    chk("R5 long frame pwr", 64'(pwr_state), 64'd0);
    send(mk(8'h81, 1'b0, 48'h8000_0000_0000, 1'b0), FB);
    chk("R5 full frame after discard", 64'(pwr_state), 64'd2);

    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears banks", 64'(ctrl_reg | adj_reg), 64'd0);
    chk("R1 reset clears pwr", 64'(pwr_state), 64'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule